// File: doc/BRIEF.md
# Warp Lane Utilization Monitor

This block watches the instruction issue port of one SIMT warp. Each issue arrives with a valid strobe, a per-lane active mask and a flag that marks the issue as predicated. The block keeps three running totals: the number of issues, the number of lanes that were active across all of them, and the number of issues made with only part of the warp active. Lanes that are masked off still use up an issue, so they raise the issue count and add nothing to the lane total. A predicated instruction goes to every lane, and its predicate only gates write-back, so it counts as a full-width issue whatever its mask.

On request the block takes a snapshot of the totals. A multi-cycle restoring divider then turns the snapshot into the average fraction of active lanes per issue, in 8.8 fixed point. An undiverged warp reads 1.0 (256). An even two-way split reads 0.5 (128). An even k-way split reads 1/k. A clear input returns the block to its reset state. Several monitors can be combined by adding their totals outside the block.

Top module: `warp_lane_util_mon`

## Requirements
- R1: After reset all three counters read 0, `eff_q` is 0, and `eff_vld` and `busy` are low.
- R2: The issue counter rises by exactly 1 on each cycle where `issue_vld` is high. When `issue_vld` is low, no counter changes, whatever the mask and predicate inputs are.
- R3: On a valid issue that is not predicated, the lane counter rises by the number of 1 bits in `issue_mask`. Bit i of the mask is lane i.
- R4: On a valid issue with `issue_pred` high, the lane counter rises by LANES and the partial counter does not change. The mask has no effect.
- R5: The partial counter rises by 1 on a valid issue that is not predicated and whose mask is not all ones. An all-zero mask counts as partial.
- R6: A snapshot request accepted in cycle t divides the counter values held in cycle t. The result is floor(lane_sum*256/(issue_cnt*LANES)) on `eff_q`, with `eff_vld` high. An undiverged warp gives 256, a 2-way even split 128, a 4-way split 64 and an 8-way split 32.
- R7: A snapshot taken while the issue counter is 0 gives `eff_q` = 0 and `eff_vld` low.
- R8: `busy` is high from the cycle after an accepted snapshot until the result is written, which takes at most CNT_W+FRAC_W+1 cycles. A snapshot request made while `busy` is high is ignored.
- R9: `clr` zeroes all counters, `eff_q` and `eff_vld` on the next edge, and abandons a division in progress. It takes priority over an issue or a snapshot request in the same cycle.
- R10: Each counter saturates at all ones and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all totals and results |
| issue_vld | input | 1 | An instruction issues this cycle |
| issue_pred | input | 1 | Issue is predicated (counted full width) |
| issue_mask | input | LANES | Active lane mask, bit i = lane i |
| snap_req | input | 1 | Request an efficiency snapshot |
| busy | output | 1 | Division in progress |
| eff_q | output | FRAC_W+8 | Average active fraction, fixed point |
| eff_vld | output | 1 | eff_q holds a result with a nonzero issue count |
| issue_cnt | output | CNT_W | Total issues |
| lane_sum | output | CNT_W | Total active lanes |
| partial_cnt | output | CNT_W | Issues with a partial mask |

## Verification
The bench builds the block with LANES=8 and CNT_W=12. With only 8 lanes it can apply all 256 masks and check each popcount and partial decision. With 12-bit counters, saturation of both the lane counter and the issue counter is reachable within a few thousand cycles. Efficiency snapshots are compared against floor arithmetic on a bench-side model of the counters. These cover the even k-way splits, predicated issues with empty masks, a count of zero, snapshots issued while busy, and clears that land in the middle of a division.

// File: rtl/lane_util_pkg.sv
package lane_util_pkg;
  typedef enum logic [0:0] {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/lane_popcount.sv
module lane_popcount #(
  parameter int LANES = 32,
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] mask,
  output logic [CW-1:0]    count
);
  logic [CW-1:0] psum [LANES+1];

  assign psum[0] = '0;
  for (genvar i = 0; i < LANES; i++) begin : g_chain
    assign psum[i+1] = psum[i] + CW'(mask[i]);
  end
  assign count = psum[LANES];
endmodule

// File: rtl/sat_ctr.sv
module sat_ctr #(
  parameter int W  = 32,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  q
);
  logic [W:0]   sum_w;
  logic [W-1:0] q_nx;

  always_comb begin
    sum_w = {1'b0, q} + {{(W + 1 - IW){1'b0}}, inc};
    q_nx  = q;
    if (clr)     q_nx = '0;
    else if (en) q_nx = sum_w[W] ? '1 : sum_w[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nx;
  end

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> q >= $past(q));
endmodule

// File: rtl/util_divider.sv
module util_divider
  import lane_util_pkg::*;
#(
  parameter int NW = 40,
  parameter int DW = 37,
  parameter int QW = 16,
  localparam int CNTW = $clog2(NW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic [QW-1:0] q_out,
  output logic          q_vld
);
  div_state_e    st, st_nx;
  logic [CNTW-1:0] step, step_nx;
  logic [NW-1:0] dvd, dvd_nx, quo, quo_nx;
  logic [DW-1:0] rem, rem_nx, dr, dr_nx;
  logic [DW:0]   rem_sh;
  logic          qbit, fin;
  logic [QW-1:0] q_nx;
  logic          v_nx;

  always_comb begin
    st_nx   = st;
    step_nx = step;
    dvd_nx  = dvd;
    quo_nx  = quo;
    rem_nx  = rem;
    dr_nx   = dr;
    q_nx    = q_out;
    v_nx    = q_vld;
    rem_sh  = {rem, dvd[NW-1]};
    qbit    = rem_sh >= {1'b0, dr};
    fin     = 1'b0;
    if (clr) begin
      st_nx = DIV_IDLE;
      q_nx  = '0;
      v_nx  = 1'b0;
    end else if (st == DIV_IDLE) begin
      if (start) begin
        st_nx   = DIV_RUN;
        step_nx = '0;
        dvd_nx  = num;
        quo_nx  = '0;
        rem_nx  = '0;
        dr_nx   = den;
      end
    end else begin
      rem_nx  = qbit ? DW'(rem_sh - {1'b0, dr}) : rem_sh[DW-1:0];
      quo_nx  = {quo[NW-2:0], qbit};
      dvd_nx  = {dvd[NW-2:0], 1'b0};
      step_nx = step + 1'b1;
      if (step == CNTW'(NW - 1)) begin
        fin   = 1'b1;
        st_nx = DIV_IDLE;
        v_nx  = (dr != '0);
        q_nx  = (dr != '0) ? quo_nx[QW-1:0] : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= DIV_IDLE;
      step  <= '0;
      dvd   <= '0;
      quo   <= '0;
      rem   <= '0;
      dr    <= '0;
      q_out <= '0;
      q_vld <= 1'b0;
    end else begin
      st    <= st_nx;
      step  <= step_nx;
      dvd   <= dvd_nx;
      quo   <= quo_nx;
      rem   <= rem_nx;
      dr    <= dr_nx;
      q_out <= q_nx;
      q_vld <= v_nx;
    end
  end

  assign busy = (st == DIV_RUN);

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !clr) |=> busy);
  // R8
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> step < CNTW'(NW));
  // R7
  zero_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fin && !clr && dr == '0) |=> !q_vld && q_out == '0);
endmodule

// File: rtl/warp_lane_util_mon.sv
module warp_lane_util_mon #(
  parameter int LANES  = 32,
  parameter int CNT_W  = 32,
  parameter int FRAC_W = 8,
  localparam int PCW   = $clog2(LANES + 1),
  localparam int EFF_W = FRAC_W + 8,
  localparam int NUM_W = CNT_W + FRAC_W,
  localparam int DEN_W = CNT_W + PCW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             issue_vld,
  input  logic             issue_pred,
  input  logic [LANES-1:0] issue_mask,
  input  logic             snap_req,
  output logic             busy,
  output logic [EFF_W-1:0] eff_q,
  output logic             eff_vld,
  output logic [CNT_W-1:0] issue_cnt,
  output logic [CNT_W-1:0] lane_sum,
  output logic [CNT_W-1:0] partial_cnt
);
  logic [PCW-1:0]   mask_pc, lane_inc;
  logic             is_partial, snap_go;
  logic [NUM_W-1:0] div_num;
  logic [DEN_W-1:0] div_den;

  lane_popcount #(.LANES(LANES)) u_pc (.mask(issue_mask), .count(mask_pc));

  always_comb begin
    lane_inc   = issue_pred ? PCW'(LANES) : mask_pc;
    is_partial = !issue_pred && (issue_mask != '1);
    snap_go    = snap_req && !busy && !clr;
    div_num    = {lane_sum, {FRAC_W{1'b0}}};
    div_den    = DEN_W'(issue_cnt) * DEN_W'(LANES);
  end

  sat_ctr #(.W(CNT_W), .IW(1)) u_issue (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(issue_vld),
    .inc(1'b1), .q(issue_cnt));

  sat_ctr #(.W(CNT_W), .IW(PCW)) u_lanes (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(issue_vld),
    .inc(lane_inc), .q(lane_sum));

  sat_ctr #(.W(CNT_W), .IW(1)) u_part (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(issue_vld && is_partial),
    .inc(1'b1), .q(partial_cnt));

  util_divider #(.NW(NUM_W), .DW(DEN_W), .QW(EFF_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(snap_go),
    .num(div_num), .den(div_den),
    .busy(busy), .q_out(eff_q), .q_vld(eff_vld));

  // R6
  eff_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eff_vld |-> eff_q <= EFF_W'(1 << FRAC_W));
  // R5
  partial_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
    partial_cnt <= issue_cnt || issue_cnt == '1);
  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> issue_cnt == '0 && lane_sum == '0 && partial_cnt == '0 && !eff_vld && !busy);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_vld && !clr) |=> $stable(issue_cnt) && $stable(lane_sum) && $stable(partial_cnt));
  // R4
  pred_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && issue_pred && !clr) |=> $stable(partial_cnt));
endmodule

// File: tb/test_warp_lane_util_mon.sv
module test_warp_lane_util_mon;
  localparam int LANES = 8;
  localparam int CNT_W = 12;
  localparam int FRAC_W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int MAXC = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic issue_vld = 1'b0, issue_pred = 1'b0, snap_req = 1'b0;
  logic [LANES-1:0] issue_mask = '0;
  logic busy, eff_vld;
  logic [FRAC_W+7:0] eff_q;
  logic [CNT_W-1:0] issue_cnt, lane_sum, partial_cnt;

  int n_chk = 0, n_bad = 0;
  int m_iss = 0, m_sum = 0, m_part = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  warp_lane_util_mon #(.LANES(LANES), .CNT_W(CNT_W), .FRAC_W(FRAC_W)) i_warp_lane_util_mon (
    .clk(clk), .rst_n(rst_n), .clr(clr), .issue_vld(issue_vld), .issue_pred(issue_pred),
    .issue_mask(issue_mask), .snap_req(snap_req), .busy(busy), .eff_q(eff_q),
    .eff_vld(eff_vld), .issue_cnt(issue_cnt), .lane_sum(lane_sum), .partial_cnt(partial_cnt));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  task automatic issue(input logic [LANES-1:0] m, input logic p);
    @(negedge clk);
    issue_vld = 1'b1; issue_mask = m; issue_pred = p;
    @(negedge clk);
    issue_vld = 1'b0; issue_mask = '1; issue_pred = 1'b0;
    m_iss = sat(m_iss + 1);
    m_sum = sat(m_sum + (p ? LANES : $countones(m)));
    if (!p && m != '1) m_part = sat(m_part + 1);
  endtask

  task automatic check_counts(input string req);
    chk({req, " issue_cnt"}, int'(issue_cnt), m_iss);
    chk({req, " lane_sum"}, int'(lane_sum), m_sum);
    chk({req, " partial_cnt"}, int'(partial_cnt), m_part);
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    m_iss = 0; m_sum = 0; m_part = 0;
  endtask

  task automatic snap_and_check(input string req);
    int exp_q, lim;
    exp_q = (m_iss == 0) ? 0 : (m_sum * 256) / (m_iss * LANES);
    @(negedge clk); snap_req = 1'b1;
    @(negedge clk); snap_req = 1'b0;
    chk({req, " busy after snap"}, int'(busy), 1);
    lim = 0;
    while (busy && lim < 100) begin @(negedge clk); lim++; end
    chk({req, " done in bound R8"}, int'(lim <= CNT_W + FRAC_W), 1);
    chk({req, " eff_q"}, int'(eff_q), exp_q);
    chk({req, " eff_vld"}, int'(eff_vld), (m_iss != 0) ? 1 : 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    check_counts("R1");
    chk("R1 eff_q", int'(eff_q), 0);
    chk("R1 eff_vld", int'(eff_vld), 0);
    chk("R1 busy", int'(busy), 0);

    // R7 snapshot with zero issues
    snap_and_check("R7");

    // R2 idle cycles with garbage inputs change nothing
    @(negedge clk); issue_mask = 8'h5A; issue_pred = 1'b1;
    @(negedge clk); @(negedge clk); issue_pred = 1'b0;
    check_counts("R2 idle");

    // R3 R5 exhaustive mask sweep
    for (int m = 0; m < 256; m++) begin
      issue(LANES'(m), 1'b0);
      check_counts("R3 R5 sweep");
    end
    snap_and_check("R6 sweep");

    // R4 predicated issues, mask ignored
    do_clr();
    check_counts("R9 clear");
    for (int m = 0; m < 256; m += 17) issue(LANES'(m), 1'b1);
    check_counts("R4 pred");
    snap_and_check("R4 R6 pred full");

    // R6 even k-way splits
    do_clr();
    for (int i = 0; i < 10; i++) issue(8'hFF, 1'b0);
    snap_and_check("R6 uniform");
    do_clr();
    for (int i = 0; i < 10; i++) issue(8'h0F, 1'b0);
    snap_and_check("R6 2way");
    do_clr();
    for (int i = 0; i < 12; i++) issue(8'h03 << (2 * (i % 4)), 1'b0);
    snap_and_check("R6 4way");
    do_clr();
    for (int i = 0; i < 16; i++) issue(8'h01 << (i % 8), 1'b0);
    snap_and_check("R6 8way");
    do_clr();
    for (int i = 0; i < 7; i++) issue(LANES'(i * 37), i[0]);
    snap_and_check("R6 mixed");

    // R8 snapshot while busy is ignored; result is from first snapshot
    do_clr();
    for (int i = 0; i < 4; i++) issue(8'hFF, 1'b0);
    begin
      int lim;
      @(negedge clk); snap_req = 1'b1;
      @(negedge clk); snap_req = 1'b0; issue_vld = 1'b1; issue_mask = 8'h00;
      @(negedge clk); issue_vld = 1'b0; issue_mask = '1; snap_req = 1'b1;
      @(negedge clk); snap_req = 1'b0;
      m_iss = 5; m_part = 1;
      lim = 0;
      while (busy && lim < 100) begin @(negedge clk); lim++; end
      chk("R8 ignored snap eff_q", int'(eff_q), 256);
      chk("R8 busy dropped", int'(busy), 0);
      @(negedge clk);
      chk("R8 no restart", int'(busy), 0);
      check_counts("R8 counts");
    end
    snap_and_check("R8 later snap");

    // R9 clear during division, and clear beats issue and snap
    snap_req = 1'b0;
    @(negedge clk); snap_req = 1'b1;
    @(negedge clk); snap_req = 1'b0;
    @(negedge clk); @(negedge clk);
    clr = 1'b1; issue_vld = 1'b1; issue_mask = 8'h01; snap_req = 1'b1;
    @(negedge clk);
    clr = 1'b0; issue_vld = 1'b0; issue_mask = '1; snap_req = 1'b0;
    m_iss = 0; m_sum = 0; m_part = 0;
    check_counts("R9 priority");
    chk("R9 busy", int'(busy), 0);
    chk("R9 eff_vld", int'(eff_vld), 0);
    chk("R9 eff_q", int'(eff_q), 0);

    // R10 saturation of lane sum, then issue count
    for (int i = 0; i < 4200; i++) issue(8'hFF, 1'b0);
    check_counts("R10 saturate");
    chk("R10 issue at max", int'(issue_cnt), MAXC);
    snap_and_check("R10 R6 saturated");
    issue(8'h00, 1'b0);
    check_counts("R10 hold");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule